// File: doc/BRIEF.md
# Segment Base-Limit Translator

This block turns a two-part address, a segment number and an offset within that segment, into a single flat physical address. It keeps a small table of segments. Each entry holds a base address and a limit. Software fills the table through a write port. Each request reads the entry that the segment number selects and checks the offset against that entry's limit. If the offset is in range, the block returns base plus offset. If it is not, the block returns a trap.

The result is registered. A request presented in one cycle produces its answer on the next clock edge, with the valid, trap and address outputs aligned. A segment number beyond the table, an empty segment (limit zero) and an offset at or past the limit all give the same trap. A trapped response always carries an address of zero.

Top module: `segxlat`

## Requirements
- R1: After reset, `outValid`, `outTrap` and `outPhys` are 0, and every table entry has base 0 and limit 0.
- R2: A request whose segment number is below 8 and whose offset is strictly less than that segment's limit answers with `outTrap`=0 and `outPhys` = base + offset. For example, base 4300 with limit 400 and offset 53 gives 4353.
- R3: An offset equal to or greater than the segment's limit answers with `outTrap`=1. For example, limit 400 traps at offset 400 and at offset 852.
- R4: A segment whose limit is 0 traps on every offset, including offset 0.
- R5: A segment number of 8 or more on the 4-bit `reqSeg` answers with `outTrap`=1, whatever the table holds.
- R6: A write on `wrEn` changes the entry that `wrSeg` selects from the next clock edge on. A request to that same entry in the same cycle as the write sees the old contents.
- R7: Each response appears exactly one clock after its request, with `outValid`=1. In a cycle after one with no request, `outValid` is 0.
- R8: Whenever `outTrap` is 1, `outValid` is 1 and `outPhys` is 0.
- R9: `outPhys` is 17 bits wide and does not wrap. Base 0xFFFF plus offset 0xFFFE gives 0x1FFFD.
- R10: A write to one entry leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Table write strobe |
| wrSeg | input | 3 | Entry to write |
| wrBase | input | 16 | Base value to store |
| wrLimit | input | 16 | Limit value to store |
| reqValid | input | 1 | Translation request present |
| reqSeg | input | 4 | Segment number of the request |
| reqOffset | input | 16 | Offset within the segment |
| outValid | output | 1 | Response present (one cycle after request) |
| outTrap | output | 1 | Addressing trap for the response |
| outPhys | output | 17 | Translated physical address, 0 on trap |

## Verification
The bench probes the limit boundary from both sides: offset limit-1 must translate and offset limit must trap. A comparison written as less-or-equal would let the first address past the segment through. Segment numbers 8 and 15 check that the index is not truncated onto a real entry, which would return a valid address from the wrong segment. A write and a read to the same entry in the same cycle must see the old data, so a design that forwards the write data would translate where it should trap. The largest base plus the largest offset exposes an adder that drops its carry and wraps to a low address.

// File: rtl/segxlat_pkg.sv
package segxlat_pkg;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic capture;   // a request is being answered this cycle
    logic fault;     // the answer is a trap
  } xlatStrobe_t;

endpackage

// File: rtl/segxlat_table.sv
module segxlat_table #(
  parameter int SEG_COUNT = 8,
  parameter int ADDR_W    = 16,
  localparam int IDX_W    = $clog2(SEG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrSeg,
  input  logic [ADDR_W-1:0] wrBase,
  input  logic [ADDR_W-1:0] wrLimit,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [ADDR_W-1:0] rdBase,
  output logic [ADDR_W-1:0] rdLimit
);

  logic [ADDR_W-1:0] baseQ  [SEG_COUNT];
  logic [ADDR_W-1:0] limitQ [SEG_COUNT];
  logic [SEG_COUNT-1:0] wrHit;

  // one-hot decode of the write target
  for (genvar g = 0; g < SEG_COUNT; g++) begin : gDecode
    assign wrHit[g] = wrEn && (wrSeg == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < SEG_COUNT; i++) begin
      if (!rstN) begin
        baseQ[i]  <= '0;
        limitQ[i] <= '0;
      end else if (wrHit[i]) begin
        baseQ[i]  <= wrBase;
        limitQ[i] <= wrLimit;
      end
    end
  end

  // read before write: the register value is the pre-edge content
  assign rdBase  = baseQ[rdIdx];
  assign rdLimit = limitQ[rdIdx];

endmodule

// File: rtl/segxlat_ctrl.sv
module segxlat_ctrl
  import segxlat_pkg::*;
#(
  parameter int SEG_COUNT = 8,
  parameter int SEG_W     = 4,
  localparam int IDX_W    = $clog2(SEG_COUNT)
) (
  input  logic             reqValid,
  input  logic [SEG_W-1:0] reqSeg,
  input  logic             offsetOk,
  output logic [IDX_W-1:0] rdIdx,
  output xlatStrobe_t      strobe
);

  logic segInRange;

  assign segInRange = int'(reqSeg) < SEG_COUNT;
  assign rdIdx      = reqSeg[IDX_W-1:0];

  always_comb begin
    strobe.capture = reqValid;
    strobe.fault   = !segInRange || !offsetOk;
  end

endmodule

// File: rtl/segxlat_datapath.sv
module segxlat_datapath
  import segxlat_pkg::*;
#(
  parameter int ADDR_W  = 16,
  localparam int PHYS_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlatStrobe_t       strobe,
  input  logic [ADDR_W-1:0] segBase,
  input  logic [ADDR_W-1:0] segLimit,
  input  logic [ADDR_W-1:0] offset,
  output logic              offsetOk,
  output logic              outValid,
  output logic              outTrap,
  output logic [PHYS_W-1:0] outPhys
);

  logic [PHYS_W-1:0] sum;

  assign offsetOk = offset < segLimit;
  assign sum      = {1'b0, segBase} + {1'b0, offset};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outTrap  <= 1'b0;
      outPhys  <= '0;
    end else begin
      outValid <= strobe.capture;
      outTrap  <= strobe.capture && strobe.fault;
      outPhys  <= (strobe.capture && !strobe.fault) ? sum : '0;
    end
  end

endmodule

// File: rtl/segxlat.sv
module segxlat
  import segxlat_pkg::*;
#(
  parameter int SEG_COUNT = 8,
  parameter int SEG_W     = 4,
  parameter int ADDR_W    = 16,
  localparam int IDX_W    = $clog2(SEG_COUNT),
  localparam int PHYS_W   = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrSeg,
  input  logic [ADDR_W-1:0] wrBase,
  input  logic [ADDR_W-1:0] wrLimit,
  input  logic              reqValid,
  input  logic [SEG_W-1:0]  reqSeg,
  input  logic [ADDR_W-1:0] reqOffset,
  output logic              outValid,
  output logic              outTrap,
  output logic [PHYS_W-1:0] outPhys
);

  logic [IDX_W-1:0]  rdIdx;
  logic [ADDR_W-1:0] segBase;
  logic [ADDR_W-1:0] segLimit;
  logic              offsetOk;
  xlatStrobe_t       strobe;

  segxlat_table #(.SEG_COUNT(SEG_COUNT), .ADDR_W(ADDR_W)) u_table (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrSeg(wrSeg), .wrBase(wrBase), .wrLimit(wrLimit),
    .rdIdx(rdIdx), .rdBase(segBase), .rdLimit(segLimit)
  );

  segxlat_ctrl #(.SEG_COUNT(SEG_COUNT), .SEG_W(SEG_W)) u_ctrl (
    .reqValid(reqValid), .reqSeg(reqSeg), .offsetOk(offsetOk),
    .rdIdx(rdIdx), .strobe(strobe)
  );

  segxlat_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .segBase(segBase), .segLimit(segLimit), .offset(reqOffset),
    .offsetOk(offsetOk), .outValid(outValid), .outTrap(outTrap),
    .outPhys(outPhys)
  );

endmodule

// File: rtl/segxlat_chk.sv
module segxlat_chk #(
  parameter int SEG_COUNT = 8,
  parameter int SEG_W     = 4,
  parameter int ADDR_W    = 16,
  localparam int PHYS_W   = ADDR_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [SEG_W-1:0]  reqSeg,
  input logic [ADDR_W-1:0] reqOffset,
  input logic              outValid,
  input logic              outTrap,
  input logic [PHYS_W-1:0] outPhys
);

  // R7
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);

  // R7
  no_req_no_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid);

  // R5
  seg_range_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && int'(reqSeg) >= SEG_COUNT) |=> outTrap);

  // R8
  trap_zero_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    outTrap |-> (outValid && outPhys == '0));

  // R2
  addr_not_below_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && int'(reqSeg) < SEG_COUNT) |=>
      (outTrap || outPhys >= PHYS_W'($past(reqOffset))));

endmodule

bind segxlat segxlat_chk #(.SEG_COUNT(SEG_COUNT), .SEG_W(SEG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSeg(reqSeg),
  .reqOffset(reqOffset), .outValid(outValid), .outTrap(outTrap),
  .outPhys(outPhys)
);

// File: tb/segxlat_bench.sv
module segxlat_bench;

  typedef struct packed {
    logic [3:0]  seg;
    logic [15:0] off;
    logic        trap;
    logic [16:0] phys;
  } vec_t;

  localparam int NVEC = 11;
  // entries: 0 base 0x1000 lim 0x100, 1 base 0xFFFF lim 0xFFFF,
  //          2 base 4300 lim 400, 3 base 5 lim 0, others reset
  localparam vec_t VECS [NVEC] = '{
    '{4'd2,  16'd53,     1'b0, 17'd4353},    // R2
    '{4'd2,  16'd852,    1'b1, 17'd0},       // R3
    '{4'd2,  16'd399,    1'b0, 17'd4699},    // R2 edge
    '{4'd2,  16'd400,    1'b1, 17'd0},       // R3 edge
    '{4'd0,  16'h00FF,   1'b0, 17'h010FF},   // R2
    '{4'd0,  16'h0100,   1'b1, 17'd0},       // R3
    '{4'd1,  16'hFFFE,   1'b0, 17'h1FFFD},   // R9
    '{4'd3,  16'd0,      1'b1, 17'd0},       // R4
    '{4'd5,  16'd0,      1'b1, 17'd0},       // R1 untouched entry
    '{4'd8,  16'd0,      1'b1, 17'd0},       // R5
    '{4'd15, 16'd3,      1'b1, 17'd0}        // R5
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSeg = '0;
  logic [15:0] wrBase = '0;
  logic [15:0] wrLimit = '0;
  logic        reqValid = 1'b0;
  logic [3:0]  reqSeg = '0;
  logic [15:0] reqOffset = '0;
  logic        outValid;
  logic        outTrap;
  logic [16:0] outPhys;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  segxlat u_segxlat (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSeg(wrSeg), .wrBase(wrBase),
    .wrLimit(wrLimit), .reqValid(reqValid), .reqSeg(reqSeg),
    .reqOffset(reqOffset), .outValid(outValid), .outTrap(outTrap),
    .outPhys(outPhys)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeEntry(input logic [2:0] s, input logic [15:0] b, input logic [15:0] l);
    @(negedge clk);
    wrEn = 1'b1; wrSeg = s; wrBase = b; wrLimit = l;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic request(input string req, input logic [3:0] s, input logic [15:0] o,
                         input logic t, input logic [16:0] p);
    @(negedge clk);
    reqValid = 1'b1; reqSeg = s; reqOffset = o;
    @(posedge clk); #1;
    reqValid = 1'b0;
    chk(req, {31'd0, outValid}, 32'd1);
    chk(req, {31'd0, outTrap}, {31'd0, t});
    chk(req, {15'd0, outPhys}, {15'd0, p});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 valid", {31'd0, outValid}, 32'd0);
    chk("R1 trap", {31'd0, outTrap}, 32'd0);
    chk("R1 phys", {15'd0, outPhys}, 32'd0);
    @(negedge clk); rstN = 1'b1;

    // R1 empty table traps
    request("R1", 4'd0, 16'd0, 1'b1, 17'd0);

    writeEntry(3'd0, 16'h1000, 16'h0100);
    writeEntry(3'd1, 16'hFFFF, 16'hFFFF);
    writeEntry(3'd2, 16'd4300, 16'd400);
    writeEntry(3'd3, 16'd5, 16'd0);

    for (int i = 0; i < NVEC; i++)
      request("R2/R3/R4/R5/R9 vector", VECS[i].seg, VECS[i].off, VECS[i].trap, VECS[i].phys);

    // R7 idle cycle gives no response
    @(negedge clk); @(posedge clk); #1;
    chk("R7 idle", {31'd0, outValid}, 32'd0);

    // R6 same-cycle write and read sees old (reset) entry -> trap
    @(negedge clk);
    wrEn = 1'b1; wrSeg = 3'd6; wrBase = 16'd100; wrLimit = 16'd10;
    reqValid = 1'b1; reqSeg = 4'd6; reqOffset = 16'd5;
    @(posedge clk); #1;
    wrEn = 1'b0; reqValid = 1'b0;
    chk("R6 old value trap", {31'd0, outTrap}, 32'd1);
    chk("R6 old value phys", {15'd0, outPhys}, 32'd0);
    // R6 next cycle sees new
    request("R6", 4'd6, 16'd5, 1'b0, 17'd105);
    request("R6 limit", 4'd6, 16'd10, 1'b1, 17'd0);

    // R10 other entries unchanged
    request("R10", 4'd2, 16'd53, 1'b0, 17'd4353);
    request("R10", 4'd7, 16'd0, 1'b1, 17'd0);

    // R7 back-to-back requests each answered next cycle
    @(negedge clk);
    reqValid = 1'b1; reqSeg = 4'd0; reqOffset = 16'd1;
    @(posedge clk); #1;
    chk("R7 b2b first", {15'd0, outPhys}, 32'h1001);
    @(negedge clk); reqSeg = 4'd2; reqOffset = 16'd0;
    @(posedge clk); #1;
    reqValid = 1'b0;
    chk("R7 b2b second", {15'd0, outPhys}, 32'd4300);
    chk("R7 b2b valid", {31'd0, outValid}, 32'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule